// File: doc/BRIEF.md
# Processor Execution Mode Controller

This block holds the privilege and addressing state of a processor core. The state is one of three modes. Slave is the user mode: it runs with appended 24-bit addressing and without privilege. Master runs with appended 24-bit addressing and full privilege. Absolute runs with privilege and uses only 18-bit absolute addresses. Each cycle the decode stage presents one instruction's attributes: whether the opcode is privileged, its interrupt-inhibit bit, whether it is a transfer, and whether its operand address came through the appending path. Fault and interrupt events arrive on their own inputs. The controller returns the current mode, a one-cycle illegal-procedure strobe, the effective interrupt inhibit and the active address width.

The controller has three named states: `MODE_SLAVE` (encoding 0), `MODE_MASTER` (1) and `MODE_ABS` (2). It has three transitions:
- **take_event**: from any state to `MODE_ABS` on a fault or an interrupt.
- **leave_abs**: from `MODE_ABS` to `MODE_MASTER` or `MODE_SLAVE` on a transfer whose operand was appended. The target comes from `tgt_master_i`, which is driven from the segment descriptor.
- **hold**: every other case leaves the state unchanged.

Reset enters `MODE_ABS`. When an event and a leave_abs request arrive in the same cycle, the event wins.

Top module: `exec_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2 (absolute), `addr_bits_o` is 18 and `illegal_proc_o` is 0.
- R2: A fault (`fault_i`) or an interrupt (`intr_i`) in any cycle makes `mode_o` equal 2 after the next clock edge, from any mode.
- R3: In absolute mode, a valid transfer with `via_append_i`=1 sets `mode_o` after the next edge to 1 if `tgt_master_i`=1 and to 0 if `tgt_master_i`=0.
- R4: In absolute mode, a transfer without appending, or an appended instruction that is not a transfer, leaves `mode_o` at 2.
- R5: In master or slave mode, without an event, `mode_o` does not change, even on an appended transfer.
- R6: A valid privileged instruction in slave mode raises `illegal_proc_o` for exactly the one cycle after the edge. Neither that instruction nor the strobe changes `mode_o`.
- R7: Privileged instructions in master or absolute mode never raise `illegal_proc_o`.
- R8: `intr_inhibit_o` equals `instr_valid_i & inhibit_bit_i` in master and absolute modes, within the same cycle. It is always 0 in slave mode.
- R9: `addr_bits_o` is 18 in absolute mode and 24 in master and slave modes.
- R10: When an event coincides with a leave_abs request, the next mode is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Decoded instruction present this cycle |
| priv_op_i | input | 1 | Opcode is privileged |
| inhibit_bit_i | input | 1 | Instruction's interrupt-inhibit bit |
| transfer_i | input | 1 | Instruction is a transfer |
| via_append_i | input | 1 | Operand address formed by appending |
| tgt_master_i | input | 1 | Privilege of transfer target (1 = master) |
| fault_i | input | 1 | Fault taken this cycle |
| intr_i | input | 1 | Interrupt taken this cycle |
| mode_o | output | 2 | Current mode: 0 slave, 1 master, 2 absolute |
| illegal_proc_o | output | 1 | Illegal-procedure fault strobe |
| intr_inhibit_o | output | 1 | Effective interrupt inhibit |
| addr_bits_o | output | 5 | Active address width in bits (18 or 24) |
| privileged_o | output | 1 | Current mode has privilege |

## Verification
The bench drives transfers from absolute mode with each combination of appended and non-appended operand, and with both target privileges. This shows that only the appended transfer leaves absolute mode and that the target input selects the mode it enters. Privileged opcodes and inhibit bits are applied in each of the three modes. The illegal strobe must appear only in slave mode, and the inhibit must be masked only there. Faults and interrupts are raised from master and slave. One event coincides with a leave request, which shows that the event has priority.

// File: rtl/exec_mode_pkg.sv
package exec_mode_pkg;
    typedef enum logic [1:0] {
        MODE_SLAVE  = 2'd0,
        MODE_MASTER = 2'd1,
        MODE_ABS    = 2'd2
    } xmode_e;
endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
    import exec_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   event_i,
    input  logic   leave_req_i,
    input  logic   tgt_master_i,
    output xmode_e mode_q
);
    xmode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (event_i) begin
            mode_d = MODE_ABS;                 // take_event
        end else begin
            unique case (mode_q)
                MODE_ABS: begin
                    if (leave_req_i)            // leave_abs
                        mode_d = tgt_master_i ? MODE_MASTER : MODE_SLAVE;
                end
                MODE_MASTER, MODE_SLAVE: mode_d = mode_q;  // hold
                default: mode_d = MODE_ABS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_ABS;
        else        mode_q <= mode_d;
    end

    assert_event_to_abs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> mode_q == MODE_ABS);

    assert_leave_abs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ABS && leave_req_i && !event_i)
        |=> mode_q == ($past(tgt_master_i) ? MODE_MASTER : MODE_SLAVE));

    assert_appended_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_ABS && !event_i) |=> $stable(mode_q));
endmodule

// File: rtl/mode_outputs.sv
module mode_outputs
    import exec_mode_pkg::*;
#(
    parameter int ABS_BITS = 18,
    parameter int APP_BITS = 24,
    parameter int BITS_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xmode_e            mode_i,
    input  logic              instr_valid_i,
    input  logic              priv_op_i,
    input  logic              inhibit_bit_i,
    output logic              illegal_q,
    output logic              inhibit_o,
    output logic [BITS_W-1:0] addr_bits_o,
    output logic              privileged_o
);
    logic slave_viol;

    always_comb begin
        privileged_o = 1'b1;
        addr_bits_o  = BITS_W'(APP_BITS);
        unique case (mode_i)
            MODE_SLAVE:  privileged_o = 1'b0;
            MODE_MASTER: privileged_o = 1'b1;
            MODE_ABS:    addr_bits_o  = BITS_W'(ABS_BITS);
            default:     addr_bits_o  = BITS_W'(ABS_BITS);
        endcase
        inhibit_o  = privileged_o & instr_valid_i & inhibit_bit_i;
        slave_viol = !privileged_o & instr_valid_i & priv_op_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= slave_viol;
    end

    assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> $past(mode_i == MODE_SLAVE && instr_valid_i && priv_op_i));

    assert_no_priv_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_SLAVE) |=> !illegal_q);

    assert_slave_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SLAVE) |-> !inhibit_o);
endmodule

// File: rtl/exec_mode_ctrl.sv
module exec_mode_ctrl
    import exec_mode_pkg::*;
#(
    parameter int ABS_BITS = 18,
    parameter int APP_BITS = 24,
    localparam int BITS_W  = $clog2(APP_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid_i,
    input  logic              priv_op_i,
    input  logic              inhibit_bit_i,
    input  logic              transfer_i,
    input  logic              via_append_i,
    input  logic              tgt_master_i,
    input  logic              fault_i,
    input  logic              intr_i,
    output logic [1:0]        mode_o,
    output logic              illegal_proc_o,
    output logic              intr_inhibit_o,
    output logic [BITS_W-1:0] addr_bits_o,
    output logic              privileged_o
);
    xmode_e mode_q;
    logic   any_event;
    logic   leave_req;

    assign any_event = fault_i | intr_i;
    assign leave_req = instr_valid_i & transfer_i & via_append_i;

    mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .event_i      (any_event),
        .leave_req_i  (leave_req),
        .tgt_master_i (tgt_master_i),
        .mode_q       (mode_q)
    );

    mode_outputs #(
        .ABS_BITS (ABS_BITS),
        .APP_BITS (APP_BITS),
        .BITS_W   (BITS_W)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_q),
        .instr_valid_i (instr_valid_i),
        .priv_op_i     (priv_op_i),
        .inhibit_bit_i (inhibit_bit_i),
        .illegal_q     (illegal_proc_o),
        .inhibit_o     (intr_inhibit_o),
        .addr_bits_o   (addr_bits_o),
        .privileged_o  (privileged_o)
    );

    assign mode_o = mode_q;

    assert_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_bits_o == ((mode_o == 2'd2) ? BITS_W'(ABS_BITS) : BITS_W'(APP_BITS)));

    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_event && leave_req) |=> mode_o == 2'd2);
endmodule

// File: tb/sim_exec_mode_ctrl.sv
`timescale 1ns/1ps
module sim_exec_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 0, priv = 0, inh = 0, xfer = 0, app = 0, tgt = 0, flt = 0, irq = 0;
    logic [1:0] mode;
    logic       ill, inh_o, privd;
    logic [4:0] bits;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    exec_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(valid), .priv_op_i(priv),
        .inhibit_bit_i(inh), .transfer_i(xfer), .via_append_i(app),
        .tgt_master_i(tgt), .fault_i(flt), .intr_i(irq), .mode_o(mode),
        .illegal_proc_o(ill), .intr_inhibit_o(inh_o), .addr_bits_o(bits),
        .privileged_o(privd)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        valid = 0; priv = 0; inh = 0; xfer = 0; app = 0; tgt = 0; flt = 0; irq = 0;
    endtask

    // inputs already set at a negedge; cross one posedge, land on next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic leave_abs(input logic to_master);
        valid = 1; xfer = 1; app = 1; tgt = to_master;
        step();
    endtask

    task automatic t_reset();
        chk(mode, 2, "R1 mode");
        chk(bits, 18, "R1 bits");
        chk(ill, 0, "R1 strobe");
    endtask

    task automatic t_abs_hold();
        valid = 1; xfer = 1; app = 0; step();
        chk(mode, 2, "R4 plain transfer");
        valid = 1; xfer = 0; app = 1; step();
        chk(mode, 2, "R4 appended non-transfer");
    endtask

    task automatic t_slave_path();
        leave_abs(1'b0);
        chk(mode, 0, "R3 to slave");
        chk(bits, 24, "R9 slave width");
        valid = 1; inh = 1; #1;
        chk(inh_o, 0, "R8 slave mask");
        valid = 1; priv = 1; step();
        chk(ill, 1, "R6 strobe high");
        chk(mode, 0, "R6 mode kept");
        step();
        chk(ill, 0, "R6 strobe one cycle");
        chk(mode, 0, "R6 strobe no mode change");
        valid = 1; xfer = 1; app = 1; tgt = 1; step();
        chk(mode, 0, "R5 slave hold");
        flt = 1; step();
        chk(mode, 2, "R2 fault from slave");
        chk(bits, 18, "R9 abs width");
    endtask

    task automatic t_master_path();
        leave_abs(1'b1);
        chk(mode, 1, "R3 to master");
        chk(bits, 24, "R9 master width");
        valid = 1; inh = 1; #1;
        chk(inh_o, 1, "R8 master honour");
        valid = 1; priv = 1; step();
        chk(ill, 0, "R7 master priv");
        valid = 1; xfer = 1; app = 1; tgt = 0; step();
        chk(mode, 1, "R5 master hold");
        irq = 1; step();
        chk(mode, 2, "R2 interrupt from master");
    endtask

    task automatic t_abs_priv();
        valid = 1; inh = 1; #1;
        chk(inh_o, 1, "R8 abs honour");
        valid = 1; priv = 1; step();
        chk(ill, 0, "R7 abs priv");
        chk(mode, 2, "R7 abs mode");
    endtask

    task automatic t_event_wins();
        valid = 1; xfer = 1; app = 1; tgt = 1; flt = 1; step();
        chk(mode, 2, "R10 fault beats leave");
        valid = 1; xfer = 1; app = 1; tgt = 0; irq = 1; step();
        chk(mode, 2, "R10 interrupt beats leave");
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_abs_hold();
        t_slave_path();
        t_master_path();
        t_abs_priv();
        t_event_wins();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule